// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller. Pins are grouped in banks of 32, and the number of banks is a parameter. Software drives output latches through separate set and clear words. It can read back both the output latches and the filtered pin inputs. Each pin has its own control word, which selects direction, the edge that raises an interrupt, and an optional debounce filter.

Every pin input first passes through a two-flop synchronizer. It may then be held back by a debounce filter. The filter accepts a new level only after that level has stayed unchanged for 2^code ticks of a 1 ms strobe. Selected edges of the accepted level latch a per-bank status bit. A status bit is set whatever its mask bit holds. Each bank drives one interrupt line, raised while any status bit whose mask bit is 0 is set.

Pin p belongs to bank p/32, at bit p%32 of that bank's words. Byte addresses are as follows:
- Per-bank words at 4-byte stride: output latch 0x00, input level 0x20, output set 0x40, output clear 0x60, status 0x80, mask 0xA0, mask clear 0xC0.
- Pin control words at 0x100 + 4·p.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every pin is an input (pin_oe all 0), all output latches and status bits are 0, every mask bit is 1, and no bank_irq line is high.
- R2: A write to output-set (0x40 + 4·bank) drives each latch bit written as 1 high. A write to output-clear (0x60 + 4·bank) drives each such bit low. Bits written as 0 leave the latch unchanged. pin_out and the word at 0x00 + 4·bank show the latch.
- R3: The control word at 0x100 + 4·p holds these fields:
  - bit 0: 1 = input, 0 = output; pin_oe[p] is the inverse of this bit.
  - bits 4:3: edge select.
  - bits 7:5: debounce code.
  - bit 8: debounce enable.
  - Every other bit reads 0.
- R4: The word at 0x20 + 4·bank returns the accepted input level of each pin. This is the input after two synchronizer flops and, when enabled, the debounce filter.
- R5: Edge select 1 latches status on a rising edge of the accepted level, 2 on a falling edge, 3 on both. A value of 0 latches nothing.
- R6: Status bits (0x80 + 4·bank) are cleared by writing 1. Bits written as 0 are unaffected. A new edge in the same cycle as a clear wins.
- R7: Writing 1 to a bit of the mask word (0xA0 + 4·bank) masks that pin. Writing 1 to the same bit of the mask-clear word (0xC0 + 4·bank) unmasks it. The mask word reads back the mask, and the mask-clear word reads 0. Status bits set regardless of the mask.
- R8: bank_irq[b] is high exactly while bank b has a status bit set whose mask bit is 0.
- R9: With debounce enabled and code c, a change of the synchronized input is accepted only once it has differed from the accepted level for 2^c ms_tick pulses in a row. A shorter excursion is dropped.
- R10: A read strobe returns reg_rdata with reg_rvalid high one cycle later. Reads of unmapped, out-of-range or misaligned addresses return 0.
- R11: Pin p maps to bank p/32, bit p%32. Banks work independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ms_tick | input | 1 | One-cycle strobe every millisecond for debounce timing |
| pin_in | input | 32·NBANKS | Raw pin inputs |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| reg_rvalid | output | 1 | reg_rdata valid |
| pin_out | output | 32·NBANKS | Output latches |
| pin_oe | output | 32·NBANKS | Output enable per pin |
| bank_irq | output | NBANKS | One interrupt line per bank |

## Verification
The assertions take several things for granted:
- reg_wr and reg_rd are never high together.
- ms_tick is a single-cycle pulse.
- A pin's control word is not rewritten while its debounce check is in progress.

The stimulus honours these assumptions. It drives every strobe for exactly one cycle from the falling clock edge and issues ticks only as isolated pulses. Debounce configuration is set before the pin is toggled. Pin changes are given at least six cycles to cross the synchronizer and edge stages before they are observed.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int PINS_PER_BANK = 32;

  // word groups inside the per-bank area (address bits 7:5)
  localparam logic [2:0] GRP_OUT    = 3'd0;
  localparam logic [2:0] GRP_IN     = 3'd1;
  localparam logic [2:0] GRP_SET    = 3'd2;
  localparam logic [2:0] GRP_CLR    = 3'd3;
  localparam logic [2:0] GRP_STAT   = 3'd4;
  localparam logic [2:0] GRP_MASK   = 3'd5;
  localparam logic [2:0] GRP_UNMASK = 3'd6;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  typedef struct packed {
    logic      db_en;
    logic [2:0] db_code;
    edge_sel_e edge_sel;
    logic      dir_in;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{db_en: 1'b0, db_code: 3'd0,
                                     edge_sel: EDGE_OFF, dir_in: 1'b1};

  function automatic pin_cfg_t word_to_cfg(input logic [31:0] w);
    pin_cfg_t c;
    c.dir_in   = w[0];
    c.edge_sel = edge_sel_e'(w[4:3]);
    c.db_code  = w[7:5];
    c.db_en    = w[8];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(input pin_cfg_t c);
    logic [31:0] w;
    w      = '0;
    w[0]   = c.dir_in;
    w[4:3] = c.edge_sel;
    w[7:5] = c.db_code;
    w[8]   = c.db_en;
    return w;
  endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/gpio_pin_filter.sv
module gpio_pin_filter #(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       din,
  input  logic       db_en,
  input  logic [2:0] db_code,
  input  logic [1:0] edge_sel,
  output logic       level,
  output logic       edge_ev
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             prev_q;
  logic [CNT_W-1:0] window;
  logic             rise, fall;

  assign window = CNT_W'(1) << db_code;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (!db_en) begin
      lvl_d = din;
      cnt_d = '0;
    end else if (din == lvl_q) begin
      cnt_d = '0;
    end else if (ms_tick) begin
      if ((cnt_q + CNT_W'(1)) >= window) begin
        lvl_d = din;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
      prev_q <= lvl_q;
    end
  end

  assign rise    = lvl_q & ~prev_q;
  assign fall    = ~lvl_q & prev_q;
  assign edge_ev = (edge_sel[0] & rise) | (edge_sel[1] & fall);
  assign level   = lvl_q;

  AST_DB_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (db_en && $past(db_en) && (lvl_q != $past(lvl_q))) |-> $past(ms_tick)); // R9

  AST_NODB_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !db_en |=> (lvl_q == $past(din))); // R4

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic          stat_clr_we,
  input  logic          mask_set_we,
  input  logic          mask_clr_we,
  input  logic [PW-1:0] wdata,
  input  logic [PW-1:0] ev,
  output logic [PW-1:0] out_q,
  output logic [PW-1:0] mask_q,
  output logic [PW-1:0] stat_q,
  output logic          irq
);

  logic [PW-1:0] out_d, mask_d, stat_d;

  always_comb begin
    out_d  = out_q;
    mask_d = mask_q;
    if (set_we)      out_d  = out_d | wdata;
    if (clr_we)      out_d  = out_d & ~wdata;
    if (mask_set_we) mask_d = mask_d | wdata;
    if (mask_clr_we) mask_d = mask_d & ~wdata;
    stat_d = stat_q;
    if (stat_clr_we) stat_d = stat_d & ~wdata;
    stat_d = stat_d | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      mask_q <= '1;
      stat_q <= '0;
    end else begin
      out_q  <= out_d;
      mask_q <= mask_d;
      stat_q <= stat_d;
    end
  end

  assign irq = |(stat_q & ~mask_q);

  AST_STAT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((stat_q & $past(ev)) == $past(ev))); // R6

  AST_STAT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == '0) |=> ((stat_q & ~$past(stat_q)) == '0)); // R6

  AST_OUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((out_q & $past(wdata)) == $past(wdata))); // R2

  AST_OUT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((out_q & $past(wdata)) == '0)); // R2

  AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_set_we && (wdata == '1)) |=> !irq); // R8

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NBANKS   = 2,
  parameter int ADDR_W   = 12,
  parameter int DB_CNT_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ms_tick,
  input  logic [NBANKS*PINS_PER_BANK-1:0]   pin_in,
  input  logic                              reg_wr,
  input  logic                              reg_rd,
  input  logic [ADDR_W-1:0]                 reg_addr,
  input  logic [31:0]                       reg_wdata,
  output logic [31:0]                       reg_rdata,
  output logic                              reg_rvalid,
  output logic [NBANKS*PINS_PER_BANK-1:0]   pin_out,
  output logic [NBANKS*PINS_PER_BANK-1:0]   pin_oe,
  output logic [NBANKS-1:0]                 bank_irq
);

  localparam int NPINS  = NBANKS * PINS_PER_BANK;
  localparam int WORD_W = ADDR_W - 2;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  // address decode
  logic [WORD_W-1:0] word_idx, ctl_off;
  logic              aligned, bank_area, ctl_hit;
  logic [2:0]        grp, bidx;

  assign word_idx  = reg_addr[ADDR_W-1:2];
  assign aligned   = (reg_addr[1:0] == 2'b00);
  assign bank_area = aligned && (reg_addr[ADDR_W-1:8] == '0);
  assign grp       = reg_addr[7:5];
  assign bidx      = reg_addr[4:2];
  assign ctl_off   = word_idx - WORD_W'(64);
  assign ctl_hit   = aligned && (word_idx >= WORD_W'(64)) && (ctl_off < WORD_W'(NPINS));

  // pin configuration
  pin_cfg_t cfg_q [NPINS];
  pin_cfg_t cfg_d [NPINS];

  logic [NPINS-1:0] sync_in, level, edge_ev;

  gpio_sync2 #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(pin_in), .q(sync_in)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic cfg_we;
    assign cfg_we = reg_wr && ctl_hit && (ctl_off == WORD_W'(p));

    always_comb begin
      cfg_d[p] = cfg_q[p];
      if (cfg_we) cfg_d[p] = word_to_cfg(reg_wdata);
    end

    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) cfg_q[p] <= CFG_RESET;
      else            cfg_q[p] <= cfg_d[p];
    end

    assign pin_oe[p] = ~cfg_q[p].dir_in;

    gpio_pin_filter #(.CNT_W(DB_CNT_W)) u_filt (
      .clk(clk), .rst_n(rst_int_n), .ms_tick(ms_tick),
      .din(sync_in[p]),
      .db_en(cfg_q[p].db_en), .db_code(cfg_q[p].db_code),
      .edge_sel(cfg_q[p].edge_sel),
      .level(level[p]), .edge_ev(edge_ev[p])
    );
  end

  // per-bank registers
  logic [31:0] out_w  [NBANKS];
  logic [31:0] mask_w [NBANKS];
  logic [31:0] stat_w [NBANKS];

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic hit;
    assign hit = reg_wr && bank_area && (bidx == 3'(b));

    gpio_bank_regs #(.PW(PINS_PER_BANK)) u_bank (
      .clk(clk), .rst_n(rst_int_n),
      .set_we(hit && (grp == GRP_SET)),
      .clr_we(hit && (grp == GRP_CLR)),
      .stat_clr_we(hit && (grp == GRP_STAT)),
      .mask_set_we(hit && (grp == GRP_MASK)),
      .mask_clr_we(hit && (grp == GRP_UNMASK)),
      .wdata(reg_wdata),
      .ev(edge_ev[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .out_q(out_w[b]), .mask_q(mask_w[b]), .stat_q(stat_w[b]),
      .irq(bank_irq[b])
    );

    assign pin_out[b*PINS_PER_BANK +: PINS_PER_BANK] = out_w[b];
  end

  // read path
  logic [31:0] rdata_d, rdata_q;
  logic        rvalid_q;

  always_comb begin
    rdata_d = '0;
    if (bank_area) begin
      for (int b = 0; b < NBANKS; b++) begin
        if (bidx == 3'(b)) begin
          case (grp)
            GRP_OUT:  rdata_d = out_w[b];
            GRP_IN:   rdata_d = level[b*PINS_PER_BANK +: PINS_PER_BANK];
            GRP_STAT: rdata_d = stat_w[b];
            GRP_MASK: rdata_d = mask_w[b];
            default:  rdata_d = '0;
          endcase
        end
      end
    end else if (ctl_hit) begin
      for (int p = 0; p < NPINS; p++) begin
        if (ctl_off == WORD_W'(p)) rdata_d = cfg_to_word(cfg_q[p]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= reg_rd;
      if (reg_rd) rdata_q <= rdata_d;
    end
  end

  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_int_n)
    reg_rd |=> reg_rvalid); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_rd && !bank_area && !ctl_hit) |=> (reg_rdata == '0)); // R10

endmodule

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb;

  localparam int NB = 2;
  localparam int NP = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ms_tick;
  logic [NP-1:0] pin_in;
  logic          reg_wr, reg_rd;
  logic [11:0]   reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic          reg_rvalid;
  logic [NP-1:0] pin_out, pin_oe;
  logic [NB-1:0] bank_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  gpio_edge_ctrl #(.NBANKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pin_in(pin_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .pin_out(pin_out), .pin_oe(pin_oe), .bank_irq(bank_irq)
  );

  // monitor: pops expected read data as results arrive
  always @(negedge clk) begin
    if (reg_rvalid && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        fails++;
        $display("FAIL %s: read got %h expected %h", t, reg_rdata, e);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic chk(input logic [63:0] act, input logic [63:0] e, input string t);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); ms_tick = 1'b1;
    @(negedge clk); ms_tick = 1'b0;
    idle(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ms_tick = 1'b0; pin_in = '0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk(pin_oe, 64'h0, "R1 oe");
    chk(pin_out, 64'h0, "R1 out");
    chk({62'h0, bank_irq}, 64'h0, "R1 irq");
    rd(12'h0A0, 32'hFFFF_FFFF, "R1 mask");
    rd(12'h084, 32'h0, "R1 status");
    rd(12'h114, 32'h1, "R1 ctl");

    // R3 control word
    wr(12'h10C, 32'h0);
    chk(pin_oe, 64'h8, "R3 oe");
    rd(12'h10C, 32'h0, "R3 readback out");
    wr(12'h1A0, 32'hFFFF_01FF);
    rd(12'h1A0, 32'h0000_01F9, "R3 readback fields");
    wr(12'h1A0, 32'h1);

    // R2 set / clear
    wr(12'h040, 32'h0000_00F0);
    chk(pin_out, 64'hF0, "R2 set");
    wr(12'h060, 32'h0000_0030);
    chk(pin_out, 64'hC0, "R2 clear");
    wr(12'h040, 32'h0);
    rd(12'h000, 32'hC0, "R2 zero write");
    // R11 bank 1
    wr(12'h044, 32'h1);
    chk(pin_out, {32'h1, 32'hC0}, "R11 bank1 out");
    rd(12'h004, 32'h1, "R11 bank1 latch");

    // R4 input level
    pin_in[7] = 1'b1; pin_in[33] = 1'b1;
    idle(6);
    rd(12'h020, 32'h80, "R4 in bank0");
    rd(12'h024, 32'h2, "R4 in bank1");
    rd(12'h080, 32'h0, "R5 edge off");

    // R5 rising only
    wr(12'h11C, 32'h09);
    pin_in[7] = 1'b0; idle(6);
    rd(12'h080, 32'h0, "R5 fall ignored by rise select");
    pin_in[7] = 1'b1; idle(6);
    rd(12'h080, 32'h80, "R5 rise latched");
    chk({62'h0, bank_irq}, 64'h0, "R7 masked still latches");
    wr(12'h0C0, 32'h80);
    chk({62'h0, bank_irq}, 64'h1, "R8 irq on unmask");
    rd(12'h0C0, 32'h0, "R7 unmask reads zero");
    wr(12'h080, 32'h0);
    rd(12'h080, 32'h80, "R6 zero write no effect");
    wr(12'h080, 32'h80);
    rd(12'h080, 32'h0, "R6 w1c");
    chk({62'h0, bank_irq}, 64'h0, "R8 irq drop");

    // R5 falling and both
    wr(12'h11C, 32'h11);
    pin_in[7] = 1'b0; idle(6);
    rd(12'h080, 32'h80, "R5 falling");
    wr(12'h080, 32'h80);
    wr(12'h11C, 32'h19);
    pin_in[7] = 1'b1; idle(6);
    rd(12'h080, 32'h80, "R5 both rise");
    wr(12'h080, 32'h80);
    pin_in[7] = 1'b0; idle(6);
    rd(12'h080, 32'h80, "R5 both fall");
    wr(12'h080, 32'h80);
    wr(12'h0A0, 32'h80);
    rd(12'h0A0, 32'hFFFF_FFFF, "R7 remask");

    // R11 bank 1 interrupt
    wr(12'h184, 32'h09);
    wr(12'h0C4, 32'h2);
    pin_in[33] = 1'b0; idle(6);
    pin_in[33] = 1'b1; idle(6);
    chk({62'h0, bank_irq}, 64'h2, "R11 bank1 irq only");
    rd(12'h084, 32'h2, "R11 bank1 status");
    wr(12'h084, 32'h2);
    chk({62'h0, bank_irq}, 64'h0, "R11 bank1 cleared");

    // R9 debounce, code 2 -> 4 ticks
    wr(12'h130, 32'h149);
    pin_in[12] = 1'b1; idle(5);
    tick(); tick();
    pin_in[12] = 1'b0; idle(5);
    tick();
    rd(12'h020, 32'h0, "R9 glitch dropped");
    rd(12'h080, 32'h0, "R9 no edge from glitch");
    pin_in[12] = 1'b1; idle(5);
    tick(); tick(); tick();
    rd(12'h020, 32'h0, "R9 three ticks not enough");
    tick();
    idle(3);
    rd(12'h020, 32'h1000, "R9 accepted after window");
    rd(12'h080, 32'h1000, "R9 edge after window");

    // R10 unmapped
    rd(12'h0E0, 32'h0, "R10 unused group");
    rd(12'h01C, 32'h0, "R10 absent bank");
    rd(12'h300, 32'h0, "R10 beyond pins");
    rd(12'h002, 32'h0, "R10 misaligned");

    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule